// File: doc/BRIEF.md
# Winograd F(2,3) Streaming 1D Convolver

This block computes two consecutive outputs of a 3-tap FIR filter from a window of four input samples, using the minimal-filtering formulation: four products per window instead of six. A weight vector of three taps is loaded once through its own valid/ready port. At load time it is converted into four transformed coefficients, and these are held in registers. Data windows then stream in through a valid/ready port. Each window goes through three register stages: the add/subtract data transform, the four element-wise products, and the output sums. The two results leave through a valid/ready output port.

The transformed coefficients are kept at twice their true value. This keeps the halved middle terms exact. The final sums are therefore always even, and one arithmetic right shift returns them to the integer product scale with no loss. The results carry the sum of the input and weight fractional bit counts.

A small control state machine serialises weight loads against data traffic. It has two states. In `ST_RUN`, windows are accepted. In `ST_DRAIN`, a weight load is pending while windows are still inside the pipeline.

The transitions are:
- `ST_RUN -> ST_DRAIN` when a load is requested and the pipeline is not empty.
- `ST_DRAIN -> ST_RUN` when the pipeline becomes empty (the load completes in that cycle) or when the request is withdrawn.

Top module: `wino_f23_conv`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, `wt_ready` is 1, and the held coefficients are zero.
- R2: For a window (s0,s1,s2,s3) with taps (w0,w1,w2), `out_y0` equals s0*w0 + s1*w1 + s2*w2 exactly, in two's complement.
- R3: For the same window, `out_y1` equals s1*w0 + s2*w1 + s3*w2 exactly.
- R4: A window accepted at clock edge k into an empty pipeline, with `out_ready` held high, has `out_valid` low after edge k+1 and high after edge k+2. One window can be accepted per cycle.
- R5: While `out_valid` is 1 and `out_ready` is 0, the outputs hold their values and every stage stalls. No window is lost or duplicated.
- R6: The taps loaded by a weight handshake apply to every window accepted after it, until the next weight handshake.
- R7: `wt_ready` is 1 only when no window is in the pipeline, and `in_ready` is 0 while `wt_valid` is 1. Windows accepted before a load use the previous taps. A load and a window are never accepted in the same cycle.
- R8: Full-scale inputs (all taps and samples at the most negative value, or mixed extremes) give exact results without overflow. The output width is DW+WW+6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wt_valid | input | 1 | Weight load request |
| wt_ready | output | 1 | Weight load accepted when both this and wt_valid are 1 |
| wt_tap0 | input | WW | Tap multiplying the oldest sample of each output, signed |
| wt_tap1 | input | WW | Middle tap, signed |
| wt_tap2 | input | WW | Tap multiplying the newest sample, signed |
| in_valid | input | 1 | Window present |
| in_ready | output | 1 | Window accepted when both this and in_valid are 1 |
| win_s0 | input | DW | Window sample 0 (oldest), signed |
| win_s1 | input | DW | Window sample 1, signed |
| win_s2 | input | DW | Window sample 2, signed |
| win_s3 | input | DW | Window sample 3 (newest), signed |
| out_valid | output | 1 | Result pair present |
| out_ready | input | 1 | Downstream takes the result pair |
| out_y0 | output | DW+WW+6 | First filter output, signed |
| out_y1 | output | DW+WW+6 | Second filter output, signed |

## Verification
The bench requests a weight load while windows are still in flight. A design that swapped taps early would corrupt those older results, and one that accepted a window during the load would pair it with the wrong taps. Long random stalls on `out_ready` show whether a stage advances when it should not: results would change while held, or would be dropped or duplicated. All-negative full-scale operands target the widths. A design that saturated or truncated the two-bit growth of the data transform, or dropped the doubled coefficient bit, would return wrong sums or odd values. A single window into an empty pipeline pins the latency to exactly three register stages.

// File: rtl/wino_pkg.sv
`timescale 1ns/1ps
package wino_pkg;
    // Control states of the convolver
    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_DRAIN = 1'b1
    } wino_state_e;

    localparam int LANES = 4;
endpackage

// File: rtl/wino_ctrl.sv
`timescale 1ns/1ps
module wino_ctrl
    import wino_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wt_valid,
    input  logic pipe_empty,
    input  logic advance,
    output logic in_ready,
    output logic wt_ready
);
    wino_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (wt_valid && !pipe_empty) state_d = ST_DRAIN;
            ST_DRAIN: if (!wt_valid || pipe_empty) state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_comb begin
        wt_ready = pipe_empty;
        in_ready = 1'b0;
        unique case (state_q)
            ST_RUN:   in_ready = !wt_valid && advance;
            ST_DRAIN: in_ready = 1'b0;
            default:  in_ready = 1'b0;
        endcase
    end

    // R7: a pending load leaves the drain state once the pipeline is empty
    a_r7_drain_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && pipe_empty) |=> (state_q == ST_RUN));
endmodule

// File: rtl/wino_wxform.sv
`timescale 1ns/1ps
module wino_wxform #(
    parameter int WW = 8,
    localparam int TW = WW + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic signed [WW-1:0] w0,
    input  logic signed [WW-1:0] w1,
    input  logic signed [WW-1:0] w2,
    output logic signed [TW-1:0] tw [4]
);
    // Coefficients are held at twice their value so the halves stay exact
    logic signed [TW-1:0] e0, e1, e2;
    assign e0 = {{(TW-WW){w0[WW-1]}}, w0};
    assign e1 = {{(TW-WW){w1[WW-1]}}, w1};
    assign e2 = {{(TW-WW){w2[WW-1]}}, w2};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) tw[i] <= '0;
        end else if (load) begin
            tw[0] <= e0 <<< 1;
            tw[1] <= e0 + e1 + e2;
            tw[2] <= e0 - e1 + e2;
            tw[3] <= e2 <<< 1;
        end
    end

    // R6: held coefficients change only on a load
    a_r6_coef_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(tw[0]) && $stable(tw[1]) && $stable(tw[2]) && $stable(tw[3])));
endmodule

// File: rtl/wino_dpath.sv
`timescale 1ns/1ps
module wino_dpath #(
    parameter int DW = 8,
    parameter int TW = 11,
    localparam int XW = DW + 2,
    localparam int PW = XW + TW,
    localparam int SW = PW + 2,
    localparam int OW = SW - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_fire,
    input  logic signed [DW-1:0] s0,
    input  logic signed [DW-1:0] s1,
    input  logic signed [DW-1:0] s2,
    input  logic signed [DW-1:0] s3,
    input  logic signed [TW-1:0] tw [4],
    input  logic                 out_ready,
    output logic                 advance,
    output logic                 pipe_empty,
    output logic                 out_valid,
    output logic signed [OW-1:0] y0,
    output logic signed [OW-1:0] y1
);
    logic v1, v2;
    logic signed [XW-1:0] xs0, xs1, xs2, xs3;
    logic signed [XW-1:0] t_d [4];
    logic signed [XW-1:0] t_q [4];
    logic signed [PW-1:0] p_q [4];
    logic signed [SW-1:0] pe [4];
    logic signed [SW-1:0] sum_a, sum_b;

    assign advance    = !out_valid || out_ready;
    assign pipe_empty = !v1 && !v2 && !out_valid;

    assign xs0 = {{(XW-DW){s0[DW-1]}}, s0};
    assign xs1 = {{(XW-DW){s1[DW-1]}}, s1};
    assign xs2 = {{(XW-DW){s2[DW-1]}}, s2};
    assign xs3 = {{(XW-DW){s3[DW-1]}}, s3};

    // Data transform
    assign t_d[0] = xs0 - xs2;
    assign t_d[1] = xs1 + xs2;
    assign t_d[2] = xs2 - xs1;
    assign t_d[3] = xs1 - xs3;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0;
            v2 <= 1'b0;
            out_valid <= 1'b0;
        end else if (advance) begin
            v1 <= in_fire;
            v2 <= v1;
            out_valid <= v2;
        end
    end

    // Stage 1 and stage 2, one lane per transformed element
    for (genvar i = 0; i < 4; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                t_q[i] <= '0;
                p_q[i] <= '0;
            end else if (advance) begin
                if (in_fire) t_q[i] <= t_d[i];
                p_q[i] <= t_q[i] * tw[i];
            end
        end
        assign pe[i] = {{(SW-PW){p_q[i][PW-1]}}, p_q[i]};
    end

    // Output transform at doubled scale
    assign sum_a = pe[0] + pe[1] + pe[2];
    assign sum_b = pe[1] - pe[2] - pe[3];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y0 <= '0;
            y1 <= '0;
        end else if (advance && v2) begin
            y0 <= sum_a[SW-1:1];
            y1 <= sum_b[SW-1:1];
        end
    end

    // R2 / R3: the doubled sums are even, so the halving drops nothing
    a_r2_even_first: assert property (@(posedge clk) disable iff (!rst_n)
        v2 |-> (sum_a[0] == 1'b0));
    a_r3_even_second: assert property (@(posedge clk) disable iff (!rst_n)
        v2 |-> (sum_b[0] == 1'b0));
    // R5: a stalled result holds
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(y0) && $stable(y1)));
endmodule

// File: rtl/wino_f23_conv.sv
`timescale 1ns/1ps
module wino_f23_conv #(
    parameter int DW = 8,
    parameter int WW = 8,
    localparam int TW = WW + 3,
    localparam int OW = DW + WW + 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wt_valid,
    output logic                 wt_ready,
    input  logic signed [WW-1:0] wt_tap0,
    input  logic signed [WW-1:0] wt_tap1,
    input  logic signed [WW-1:0] wt_tap2,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [DW-1:0] win_s0,
    input  logic signed [DW-1:0] win_s1,
    input  logic signed [DW-1:0] win_s2,
    input  logic signed [DW-1:0] win_s3,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic signed [OW-1:0] out_y0,
    output logic signed [OW-1:0] out_y1
);
    logic advance, pipe_empty, in_fire, wt_fire;
    logic signed [TW-1:0] tw [4];

    assign in_fire = in_valid && in_ready;
    assign wt_fire = wt_valid && wt_ready;

    wino_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wt_valid(wt_valid), .pipe_empty(pipe_empty),
        .advance(advance), .in_ready(in_ready), .wt_ready(wt_ready)
    );

    wino_wxform #(.WW(WW)) u_wx (
        .clk(clk), .rst_n(rst_n), .load(wt_fire),
        .w0(wt_tap0), .w1(wt_tap1), .w2(wt_tap2), .tw(tw)
    );

    wino_dpath #(.DW(DW), .TW(TW)) u_dp (
        .clk(clk), .rst_n(rst_n), .in_fire(in_fire),
        .s0(win_s0), .s1(win_s1), .s2(win_s2), .s3(win_s3), .tw(tw),
        .out_ready(out_ready), .advance(advance), .pipe_empty(pipe_empty),
        .out_valid(out_valid), .y0(out_y0), .y1(out_y1)
    );

    // R7: a weight load and a window never share a cycle
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_fire && wt_fire));
    // R7: coefficients change only while nothing is in flight
    a_r7_load_empty: assert property (@(posedge clk) disable iff (!rst_n)
        wt_fire |=> !out_valid);
endmodule

// File: tb/sim_wino_f23_conv.sv
`timescale 1ns/1ps
module sim_wino_f23_conv;
    localparam int DW = 8;
    localparam int WW = 8;
    localparam int OW = DW + WW + 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wt_valid = 1'b0, wt_ready;
    logic signed [WW-1:0] wt_tap0 = '0, wt_tap1 = '0, wt_tap2 = '0;
    logic in_valid = 1'b0, in_ready;
    logic signed [DW-1:0] win_s0 = '0, win_s1 = '0, win_s2 = '0, win_s3 = '0;
    logic out_valid, out_ready = 1'b1;
    logic signed [OW-1:0] out_y0, out_y1;

    int checks = 0, bad = 0;
    bit done = 0;
    longint q0[$], q1[$];
    longint mw0 = 0, mw1 = 0, mw2 = 0;
    string tag = "R2";
    bit fi, fo, fw, hold;
    longint cy0, cy1;

    always #4 clk = ~clk;

    wino_f23_conv #(.DW(DW), .WW(WW)) u0 (.*);

    function automatic longint ref_y0(longint a, longint b, longint c,
                                      longint w0, longint w1, longint w2);
        return a*w0 + b*w1 + c*w2;
    endfunction

    task automatic chk(bit ok, string r, longint act, longint exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    // One clock: settle, record handshakes, cross posedge, update the model at negedge
    task automatic cycle();
        #1;
        fi = in_valid && in_ready;
        fo = out_valid && out_ready;
        fw = wt_valid && wt_ready;
        hold = out_valid && !out_ready;
        cy0 = out_y0; cy1 = out_y1;
        @(posedge clk);
        @(negedge clk);
        if (fw) begin
            chk(!fi, "R7 load and window together", longint'(fi), 0);
            mw0 = wt_tap0; mw1 = wt_tap1; mw2 = wt_tap2;
        end
        if (fi) begin
            q0.push_back(ref_y0(win_s0, win_s1, win_s2, mw0, mw1, mw2));
            q1.push_back(ref_y0(win_s1, win_s2, win_s3, mw0, mw1, mw2));
        end
        if (fo) begin
            if (q0.size() == 0) chk(0, "R5 unexpected output", cy0, 0);
            else begin
                longint e0 = q0.pop_front();
                longint e1 = q1.pop_front();
                chk(cy0 == e0, {tag, " y0 (R2)"}, cy0, e0);
                chk(cy1 == e1, {tag, " y1 (R3)"}, cy1, e1);
            end
        end
        if (hold) begin
            chk(out_valid && out_y0 == cy0 && out_y1 == cy1, "R5 stall hold",
                longint'(out_y0), cy0);
        end
    endtask

    task automatic put_win(longint a, longint b, longint c, longint d);
        win_s0 = DW'(a); win_s1 = DW'(b); win_s2 = DW'(c); win_s3 = DW'(d);
    endtask

    task automatic do_load(longint a, longint b, longint c);
        wt_tap0 = WW'(a); wt_tap1 = WW'(b); wt_tap2 = WW'(c);
        wt_valid = 1'b1;
        for (int i = 0; i < 40; i++) begin
            cycle();
            if (fw) break;
        end
        wt_valid = 1'b0;
    endtask

    task automatic drain();
        in_valid = 1'b0; out_ready = 1'b1;
        repeat (6) cycle();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            bad++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(out_valid == 0, "R1 out_valid", longint'(out_valid), 0);
        chk(in_ready == 1, "R1 in_ready", longint'(in_ready), 1);
        chk(wt_ready == 1, "R1 wt_ready", longint'(wt_ready), 1);
        // R1: zero coefficients give zero results
        tag = "R1";
        in_valid = 1; put_win(5, -7, 9, 3); cycle(); in_valid = 0;
        drain();

        do_load(1, 2, 3);
        // R4 latency from an empty pipeline
        tag = "R4";
        in_valid = 1; put_win(10, -20, 30, -40);
        cycle();
        chk(fi, "R4 accept", longint'(fi), 1);
        in_valid = 0;
        cycle();
        chk(out_valid == 0, "R4 not yet valid after k+1", longint'(out_valid), 0);
        cycle();
        chk(out_valid == 1, "R4 valid after k+2", longint'(out_valid), 1);
        drain();

        // R8 full-scale operands
        tag = "R8";
        do_load(-128, -128, -128);
        in_valid = 1; put_win(-128, -128, -128, -128); cycle();
        put_win(127, -128, 127, -128); cycle();
        in_valid = 0; drain();
        do_load(127, -128, 127);
        in_valid = 1; put_win(-128, 127, -128, 127); cycle();
        put_win(-128, -128, -128, -128); cycle();
        in_valid = 0; drain();

        // R7 load requested while windows are in flight
        tag = "R7";
        do_load(3, -5, 7);
        out_ready = 0;
        in_valid = 1; put_win(11, 22, -33, 44); cycle();
        put_win(-9, 8, 7, -6); cycle();
        wt_tap0 = -2; wt_tap1 = 6; wt_tap2 = -1; wt_valid = 1;
        put_win(1, 2, 3, 4);
        #1;
        chk(wt_ready == 0, "R7 wt_ready while busy", longint'(wt_ready), 0);
        chk(in_ready == 0, "R7 in_ready while load pending", longint'(in_ready), 0);
        cycle(); cycle();
        out_ready = 1;
        for (int i = 0; i < 20; i++) begin
            cycle();
            if (fw) break;
        end
        chk(fw, "R7 load completes after drain", longint'(fw), 1);
        wt_valid = 0;
        repeat (3) cycle();
        in_valid = 0; drain();

        // R6 taps persist; R5 random stalls; R2/R3 random data
        tag = "R6";
        do_load(-17, 45, 99);
        for (int n = 0; n < 3000; n++) begin
            if (n % 400 == 399) begin
                tag = "R6";
                do_load($urandom_range(255) - 128, $urandom_range(255) - 128,
                        $urandom_range(255) - 128);
            end
            in_valid = ($urandom % 4) != 0;
            out_ready = ($urandom % 3) != 0;
            put_win($urandom_range(255) - 128, $urandom_range(255) - 128,
                    $urandom_range(255) - 128, $urandom_range(255) - 128);
            cycle();
        end
        drain();
        chk(q0.size() == 0, "R5 all results delivered", q0.size(), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule